// File: doc/BRIEF.md
# Paged Memory Window Translator

The block turns a host memory address into a card memory address through five independent windows. Each window is described by a first page, a last page and a signed page offset, all counted in 4 KB pages. Software programs the windows through a bank of byte-wide registers reached by index. A global enable register switches each window on or off and selects the compare precision. For a given host address the block picks an enabled window whose page range holds the address. It then reports which window matched, the translated card address and three per-window attributes: the data path width, the timer set and whether the access goes to attribute or common card space.

Translation is combinational from `host_addr` to the outputs. Register writes land on the next rising clock edge, so a new setting applies from the cycle after the write. Software is expected to switch a window off before rewriting it. For that reason the block keeps no shadow copies and applies every byte as soon as it is written.

Top module: `pagewin_xlate`

## Requirements
- R1: After reset every register byte reads 0, no window is enabled and `hit` is 0.
- R2: Window n (0..4) owns register indexes 0x10+8n to 0x10+8n+7. Sub-offsets 0..5 are first-page low, first-page high, last-page low, last-page high, offset low and offset high. Each reads back the byte last written. Sub-offsets 6 and 7, and every index below 0x10 other than 0x06, read 0 and ignore writes.
- R3: Index 0x06 is the enable register. Bit n enables window n and bit 5 selects full-precision compare. It reads back the written byte masked to bits 5:0.
- R4: In full-precision mode a window matches when first page <= host_addr[23:12] <= last page, with both ends inclusive. The page is {high[3:0], low[7:0]}.
- R5: On a hit, card_addr = {(host page + offset) mod 2^14, host_addr[11:0]}. The offset is {offset-high[5:0], offset-low[7:0]}, so subtraction happens through two's-complement wrap.
- R6: On a hit, `wide16` is bit 7 of first-page high, `timer1` is bit 6 of last-page high and `attr_sel` is bit 6 of offset high, all taken from the selected window.
- R7: When several enabled windows match, the lowest-numbered one is selected and reported on `win_idx`.
- R8: With no enabled matching window, `hit`, `win_idx`, `card_addr`, `wide16`, `timer1` and `attr_sel` are all 0.
- R9: With enable bit 5 clear, windows compare only host_addr[23:17] against the first and last pages' matching bits (128 KB precision).
- R10: A register write changes the translation from the first cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 6 | Register index for writes |
| wr_data | input | 8 | Register write byte |
| rd_idx | input | 6 | Register index for reads |
| rd_data | output | 8 | Register read byte (combinational) |
| host_addr | input | 24 | Host memory address to translate |
| hit | output | 1 | An enabled window holds the address |
| win_idx | output | 3 | Number of the selected window |
| card_addr | output | 26 | Translated card address |
| attr_sel | output | 1 | 1 selects attribute space, 0 common space |
| wide16 | output | 1 | 16-bit data path selected |
| timer1 | output | 1 | Timer set 1 selected |

## Verification
Addresses are placed on the first and last byte of a window's range and one page beyond each end. This separates an inclusive compare from an exclusive one and shows that the in-page bits pass through. Offsets are tried both positive and negative large enough to wrap, which distinguishes modular addition from saturation or truncation. Overlapping windows enabled in different combinations expose the priority order. An address that lies outside the page range but inside the same 128 KB block tells the two compare modes apart. Readback of reserved and unused indexes after writes shows that those writes are discarded.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
  // Sub-offsets within one window's register group.
  localparam int SUB_START_LO = 0;
  localparam int SUB_START_HI = 1;
  localparam int SUB_STOP_LO  = 2;
  localparam int SUB_STOP_HI  = 3;
  localparam int SUB_OFF_LO   = 4;
  localparam int SUB_OFF_HI   = 5;

  // Flag positions in the high bytes.
  localparam int WIDE_BIT  = 7;  // first-page high
  localparam int TIMER_BIT = 6;  // last-page high
  localparam int ATTR_BIT  = 6;  // offset high

  // Bit of the enable register that selects full-precision compare.
  localparam int FULL_BIT = 5;

  typedef struct packed {
    logic [7:0] start_lo;
    logic [7:0] start_hi;
    logic [7:0] stop_lo;
    logic [7:0] stop_hi;
    logic [7:0] off_lo;
    logic [7:0] off_hi;
  } win_regs_t;
endpackage

// File: rtl/pwx_win_regs.sv
module pwx_win_regs
  import pwx_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int BASE  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output win_regs_t        regs_o
);
  localparam int GRP_W = IDX_W - 3;
  localparam logic [GRP_W-1:0] GRP = GRP_W'(BASE / 8);

  win_regs_t regs_q;
  win_regs_t regs_d;
  logic      wr_sel;

  assign wr_sel = wr_en && (wr_idx[IDX_W-1:3] == GRP) && (wr_idx[2:0] <= 3'(SUB_OFF_HI));

  always_comb begin
    regs_d = regs_q;
    case (int'(wr_idx[2:0]))
      SUB_START_LO: regs_d.start_lo = wr_data;
      SUB_START_HI: regs_d.start_hi = wr_data;
      SUB_STOP_LO:  regs_d.stop_lo  = wr_data;
      SUB_STOP_HI:  regs_d.stop_hi  = wr_data;
      SUB_OFF_LO:   regs_d.off_lo   = wr_data;
      SUB_OFF_HI:   regs_d.off_hi   = wr_data;
      default:      regs_d = regs_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_sel) begin
      regs_q <= regs_d;
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/pwx_win_match.sv
module pwx_win_match
  import pwx_pkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int COARSE_LSB = 5
) (
  input  win_regs_t         regs,
  input  logic [PAGE_W-1:0] host_page,
  input  logic              full_mode,
  output logic              match
);
  localparam int HI_W = PAGE_W - 8;
  localparam logic [PAGE_W-1:0] COARSE_MASK = ~((PAGE_W'(1) << COARSE_LSB) - PAGE_W'(1));

  logic [PAGE_W-1:0] first_pg;
  logic [PAGE_W-1:0] last_pg;
  logic [PAGE_W-1:0] mask;

  assign first_pg = {regs.start_hi[HI_W-1:0], regs.start_lo};
  assign last_pg  = {regs.stop_hi[HI_W-1:0], regs.stop_lo};
  assign mask     = full_mode ? '1 : COARSE_MASK;

  assign match = ((host_page & mask) >= (first_pg & mask)) &&
                 ((host_page & mask) <= (last_pg & mask));
endmodule

// File: rtl/pwx_select.sv
module pwx_select
  import pwx_pkg::*;
#(
  parameter int NWIN      = 5,
  parameter int PAGE_W    = 12,
  parameter int CARD_PG_W = 14
) (
  input  win_regs_t                 regs [NWIN],
  input  logic [NWIN-1:0]           cand,
  input  logic [PAGE_W+11:0]        host_addr,
  output logic                      hit,
  output logic [$clog2(NWIN)-1:0]   win_idx,
  output logic [CARD_PG_W+11:0]     card_addr,
  output logic                      attr_sel,
  output logic                      wide16,
  output logic                      timer1
);
  localparam int WI_W     = $clog2(NWIN);
  localparam int OFF_HI_W = CARD_PG_W - 8;
  localparam int EXT_W    = CARD_PG_W - PAGE_W;

  logic [WI_W-1:0]      sel;
  win_regs_t            w;
  logic [CARD_PG_W-1:0] host_pg_ext;
  logic [CARD_PG_W-1:0] off_pg;
  logic [CARD_PG_W-1:0] card_pg;

  // Lowest-numbered candidate wins: scan downward, last assignment sticks.
  always_comb begin
    sel = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (cand[i]) sel = WI_W'(i);
    end
  end

  assign w           = regs[sel];
  assign host_pg_ext = {{EXT_W{1'b0}}, host_addr[PAGE_W+11:12]};
  assign off_pg      = {w.off_hi[OFF_HI_W-1:0], w.off_lo};
  assign card_pg     = host_pg_ext + off_pg;

  always_comb begin
    hit       = |cand;
    win_idx   = '0;
    card_addr = '0;
    attr_sel  = 1'b0;
    wide16    = 1'b0;
    timer1    = 1'b0;
    if (hit) begin
      win_idx   = sel;
      card_addr = {card_pg, host_addr[11:0]};
      attr_sel  = w.off_hi[ATTR_BIT];
      wide16    = w.start_hi[WIDE_BIT];
      timer1    = w.stop_hi[TIMER_BIT];
    end
  end
endmodule

// File: rtl/pagewin_xlate.sv
module pagewin_xlate
  import pwx_pkg::*;
#(
  parameter int NWIN       = 5,
  parameter int IDX_W      = 6,
  parameter int PAGE_W     = 12,
  parameter int CARD_PG_W  = 14,
  parameter int WIN_BASE   = 16,
  parameter int ENA_IDX    = 6,
  parameter int COARSE_LSB = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [7:0]                  wr_data,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [7:0]                  rd_data,
  input  logic [PAGE_W+11:0]          host_addr,
  output logic                        hit,
  output logic [$clog2(NWIN)-1:0]     win_idx,
  output logic [CARD_PG_W+11:0]       card_addr,
  output logic                        attr_sel,
  output logic                        wide16,
  output logic                        timer1
);
  localparam int GRP_W = IDX_W - 3;
  localparam logic [7:0] ENA_MASK = 8'((1 << NWIN) - 1) | 8'(1 << FULL_BIT);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Enable register.
  logic [7:0] ena_q, ena_d;
  logic       ena_we;
  assign ena_we = wr_en && (wr_idx == IDX_W'(ENA_IDX));
  assign ena_d  = wr_data & ENA_MASK;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ena_q <= '0;
    end else if (ena_we) begin
      ena_q <= ena_d;
    end
  end

  // Per-window register groups and comparators.
  win_regs_t        regs [NWIN];
  logic [NWIN-1:0]  match;
  logic [NWIN-1:0]  cand;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    pwx_win_regs #(
      .IDX_W (IDX_W),
      .BASE  (WIN_BASE + 8 * g)
    ) i_regs (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .regs_o  (regs[g])
    );

    pwx_win_match #(
      .PAGE_W     (PAGE_W),
      .COARSE_LSB (COARSE_LSB)
    ) i_match (
      .regs      (regs[g]),
      .host_page (host_addr[PAGE_W+11:12]),
      .full_mode (ena_q[FULL_BIT]),
      .match     (match[g])
    );

    assign cand[g] = match[g] && ena_q[g];
  end

  pwx_select #(
    .NWIN      (NWIN),
    .PAGE_W    (PAGE_W),
    .CARD_PG_W (CARD_PG_W)
  ) i_select (
    .regs      (regs),
    .cand      (cand),
    .host_addr (host_addr),
    .hit       (hit),
    .win_idx   (win_idx),
    .card_addr (card_addr),
    .attr_sel  (attr_sel),
    .wide16    (wide16),
    .timer1    (timer1)
  );

  // Register readback.
  always_comb begin
    rd_data = '0;
    if (rd_idx == IDX_W'(ENA_IDX)) rd_data = ena_q;
    for (int n = 0; n < NWIN; n++) begin
      if (rd_idx[IDX_W-1:3] == GRP_W'(WIN_BASE / 8 + n)) begin
        case (int'(rd_idx[2:0]))
          SUB_START_LO: rd_data = regs[n].start_lo;
          SUB_START_HI: rd_data = regs[n].start_hi;
          SUB_STOP_LO:  rd_data = regs[n].stop_lo;
          SUB_STOP_HI:  rd_data = regs[n].stop_hi;
          SUB_OFF_LO:   rd_data = regs[n].off_lo;
          SUB_OFF_HI:   rd_data = regs[n].off_hi;
          default:      rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pagewin_xlate_chk.sv
module pagewin_xlate_chk #(
  parameter int NWIN     = 5,
  parameter int IDX_W    = 6,
  parameter int PAGE_W   = 12,
  parameter int CARD_PG_W = 14,
  parameter int WIN_BASE = 16,
  parameter int ENA_IDX  = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [IDX_W-1:0]        wr_idx,
  input logic [7:0]              wr_data,
  input logic [IDX_W-1:0]        rd_idx,
  input logic [7:0]              rd_data,
  input logic [PAGE_W+11:0]      host_addr,
  input logic                    hit,
  input logic [$clog2(NWIN)-1:0] win_idx,
  input logic [CARD_PG_W+11:0]   card_addr,
  input logic                    attr_sel,
  input logic                    wide16,
  input logic                    timer1,
  input logic [7:0]              ena_q
);
  // R8: a miss drives every result output to zero.
  p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (card_addr == '0 && win_idx == '0 && !attr_sel && !wide16 && !timer1));

  // R3: a hit only ever comes from a window whose enable bit is set.
  p_hit_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(win_idx) < NWIN) && ena_q[win_idx]);

  // R5: in-page address bits pass through untouched.
  p_inpage_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> card_addr[11:0] == host_addr[11:0]);

  // R10: an enable write is in force on the following cycle.
  p_ena_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(ENA_IDX)) |=> ena_q == ($past(wr_data) & 8'h3F));

  // R2: reserved low indexes read as zero.
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) < WIN_BASE && int'(rd_idx) != ENA_IDX) |-> rd_data == 8'h00);

  // R1: nothing is enabled while the enable byte is zero, so no hit.
  p_idle_nohit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q[NWIN-1:0] == '0) |-> !hit);
endmodule

bind pagewin_xlate pagewin_xlate_chk #(
  .NWIN      (NWIN),
  .IDX_W     (IDX_W),
  .PAGE_W    (PAGE_W),
  .CARD_PG_W (CARD_PG_W),
  .WIN_BASE  (WIN_BASE),
  .ENA_IDX   (ENA_IDX)
) i_chk (.*);

// File: tb/test_pagewin_xlate.sv
module test_pagewin_xlate;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic [7:0]  wr_data;
  logic [5:0]  rd_idx;
  logic [7:0]  rd_data;
  logic [23:0] host_addr;
  logic        hit;
  logic [2:0]  win_idx;
  logic [25:0] card_addr;
  logic        attr_sel;
  logic        wide16;
  logic        timer1;

  int total = 0;
  int bad   = 0;

  pagewin_xlate i_pagewin_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .host_addr (host_addr),
    .hit       (hit),
    .win_idx   (win_idx),
    .card_addr (card_addr),
    .attr_sel  (attr_sel),
    .wide16    (wide16),
    .timer1    (timer1)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [5:0] idx, input logic [7:0] exp);
    @(negedge clk);
    rd_idx = idx;
    #1;
    check(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  // Expected: hit, window, card address, {attr, wide, timer}.
  task automatic xl_check(input string req, input logic [23:0] addr, input logic exp_hit,
                          input logic [2:0] exp_win, input logic [25:0] exp_card,
                          input logic [2:0] exp_flags);
    @(negedge clk);
    host_addr = addr;
    #1;
    check(req, {31'h0, hit}, {31'h0, exp_hit});
    check(req, {29'h0, win_idx}, {29'h0, exp_win});
    check(req, {6'h0, card_addr}, {6'h0, exp_card});
    check(req, {29'h0, attr_sel, wide16, timer1}, {29'h0, exp_flags});
  endtask

  task automatic t_reset;
    rd_check("R1 enable reg", 6'h06, 8'h00);
    rd_check("R1 win0 start", 6'h10, 8'h00);
    rd_check("R1 win4 offhi", 6'h35, 8'h00);
    xl_check("R1 no hit", 24'h000000, 1'b0, 3'd0, 26'h0, 3'b000);
  endtask

  task automatic t_regs;
    wr(6'h25, 8'h7F);
    rd_check("R2 win2 offhi readback", 6'h25, 8'h7F);
    wr(6'h16, 8'hAA);
    rd_check("R2 sub-offset 6 ignored", 6'h16, 8'h00);
    wr(6'h03, 8'h55);
    rd_check("R2 reserved index ignored", 6'h03, 8'h00);
    wr(6'h06, 8'hFF);
    rd_check("R3 enable masked", 6'h06, 8'h3F);
    wr(6'h06, 8'h00);
    wr(6'h25, 8'h00);
  endtask

  task automatic t_range;
    wr(6'h18, 8'h23); wr(6'h19, 8'h01);
    wr(6'h1A, 8'h25); wr(6'h1B, 8'h01);
    wr(6'h1C, 8'h00); wr(6'h1D, 8'h00);
    wr(6'h06, 8'h22);
    xl_check("R4 first byte", 24'h123000, 1'b1, 3'd1, 26'h0123000, 3'b000);
    xl_check("R4 last byte",  24'h125FFF, 1'b1, 3'd1, 26'h0125FFF, 3'b000);
    xl_check("R8 above range", 24'h126000, 1'b0, 3'd0, 26'h0, 3'b000);
    xl_check("R8 below range", 24'h122FFF, 1'b0, 3'd0, 26'h0, 3'b000);
  endtask

  task automatic t_xlate;
    wr(6'h1D, 8'h3F);  // offset -0x100 pages
    xl_check("R5 negative wrap", 24'h124ABC, 1'b1, 3'd1, 26'h0024ABC, 3'b000);
    wr(6'h1D, 8'h20);  // offset +0x2000 pages
    xl_check("R5 positive", 24'h124ABC, 1'b1, 3'd1, 26'h2124ABC, 3'b000);
  endtask

  task automatic t_flags;
    wr(6'h19, 8'h81); wr(6'h1B, 8'h41); wr(6'h1D, 8'h60);
    xl_check("R6 all flags", 24'h124ABC, 1'b1, 3'd1, 26'h2124ABC, 3'b111);
  endtask

  task automatic t_prio;
    wr(6'h28, 8'h00); wr(6'h29, 8'h01);
    wr(6'h2A, 8'hFF); wr(6'h2B, 8'h01);
    wr(6'h2C, 8'h00); wr(6'h2D, 8'h00);
    wr(6'h06, 8'h2A);
    xl_check("R7 lowest wins", 24'h124000, 1'b1, 3'd1, 26'h2124000, 3'b111);
    wr(6'h06, 8'h28);
    xl_check("R10 disable applies next cycle", 24'h124000, 1'b1, 3'd3, 26'h0124000, 3'b000);
    wr(6'h30, 8'h00); wr(6'h31, 8'h08);
    wr(6'h32, 8'h00); wr(6'h33, 8'h08);
    wr(6'h06, 8'h30);
    xl_check("R7 last window", 24'h800123, 1'b1, 3'd4, 26'h0800123, 3'b000);
  endtask

  task automatic t_coarse;
    wr(6'h06, 8'h02);
    xl_check("R9 coarse hit", 24'h13A000, 1'b1, 3'd1, 26'h213A000, 3'b111);
    wr(6'h06, 8'h22);
    xl_check("R9 full miss", 24'h13A000, 1'b0, 3'd0, 26'h0, 3'b000);
  endtask

  initial begin
    #150000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_idx = '0; host_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_range;
    t_xlate;
    t_flags;
    t_prio;
    t_coarse;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule